// File: doc/BRIEF.md
# Watchdog Counter with Two-Command Clear

This block is the watchdog of a small microcontroller core. It counts ticks from one of two clock sources: a free-running watchdog oscillator, or the system clock divided by four. After a fixed number of ticks with no clear, it gives a one-cycle time-out pulse. The count is held in two registers: a prescaler and a main counter. On time-out both wrap to zero, so counting goes on.

A configuration input sets how software clears the watchdog. In single mode one clear strobe empties the prescaler and the main counter. In dual mode two distinct strobes are needed, a first and a second, in either order. A clear-pairing state machine remembers which one has been seen. States: `CLR_IDLE` (nothing pending), `CLR_HAVE1` (first seen) and `CLR_HAVE2` (second seen). Transitions:

- `CLR_IDLE` goes to `CLR_HAVE1` on a lone first strobe.
- `CLR_IDLE` goes to `CLR_HAVE2` on a lone second strobe.
- Each pending state goes back to `CLR_IDLE` when the missing strobe arrives; the clear fires in that cycle.
- Every state goes to `CLR_IDLE` whenever single mode is selected.

A mode state machine follows the core's halted flag. States: `MD_RUN`, `MD_HALT_LIVE` and `MD_HALT_HELD`. Transitions:

- `MD_RUN` goes to `MD_HALT_LIVE` when halted is seen with the oscillator source.
- `MD_RUN` goes to `MD_HALT_HELD` when halted is seen with the system-clock source.
- Each halt state goes back to `MD_RUN` when halted drops.

In `MD_HALT_HELD` the counter is frozen. A halt-entry strobe empties the counter. A time-out raised while in a halt state also raises a warm flag, which tells the reset network to apply a wake-up only and not a full reset.

Top module: `wdt_dualclr`

## Requirements
- R1: The time-out period is 2^(PRE_W+CNT_W) accepted ticks (65536 with the defaults). `tmo_pulse` goes high for exactly one cycle, in the cycle after the clock edge that samples the final tick, and counting restarts from zero.
- R2: When `src_sel`=0 only `osc_tick` is counted. When `src_sel`=1 only `sys_tick` is counted. The other tick input has no effect on the time-out timing.
- R3: When `dual_mode`=0, a `clr_one` strobe zeroes the prescaler and the main counter at the next edge, so a full period is needed again. In this mode `clr_first` and `clr_second` have no effect.
- R4: When `dual_mode`=1, a clear happens only in the cycle where both a `clr_first` and a `clr_second` have been seen since the last clear. They may arrive in either order, separated by any gap, or in the same cycle. In this mode `clr_one` has no effect, and a repeated strobe of the same kind does not complete the pair.
- R5: A `halt_enter` strobe zeroes the prescaler and the main counter at the next edge, whatever the clear mode.
- R6: From the cycle after `halted` is first sampled high, counting continues if `src_sel`=0 and stops if `src_sel`=1. The source chosen at that moment stays in force until `halted` is sampled low, and normal counting resumes in the following cycle.
- R7: `tmo_warm` is high together with `tmo_pulse` when the time-out occurs in a halt state, and low otherwise. `tmo_warm` is never high without `tmo_pulse`.
- R8: After reset both outputs are low, the counter and any pending dual-mode strobe are cleared, and counting starts on the first tick after reset is released.
- R9: A clear (from R3, R4 or R5) in the same cycle as a tick wins: that tick is not counted and no time-out comes from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low master reset |
| src_sel | input | 1 | Tick source: 0 watchdog oscillator, 1 system clock divided by four |
| dual_mode | input | 1 | Clear mode: 0 single command, 1 two commands |
| osc_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| sys_tick | input | 1 | One-cycle tick from the system clock divided by four |
| clr_one | input | 1 | Single-mode clear strobe |
| clr_first | input | 1 | Dual-mode first clear strobe |
| clr_second | input | 1 | Dual-mode second clear strobe |
| halt_enter | input | 1 | Strobe issued as the core enters halt |
| halted | input | 1 | Core is in the halted state |
| tmo_pulse | output | 1 | One-cycle time-out pulse |
| tmo_warm | output | 1 | Time-out happened while halted (warm wake-up only) |

## Verification
Timing of each result:

- A time-out is due one cycle after the final tick is presented: the pulse is registered on the same edge that samples that tick.
- Any clear affects the count from the edge that samples the strobe. In dual mode that is the edge that samples the strobe completing the pair.
- Halt gating lags `halted` by one edge, because the mode state machine registers it.

The bench drives inputs 2 ns after a rising edge. A cycle-level arithmetic model in the bench predicts the pulse and the warm flag for the coming edge from the inputs just driven. Both outputs are compared 2 ns after that edge, so every result is checked in the exact cycle it is due.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    // Dual-mode clear pairing: which strobe of the pair is pending
    typedef enum logic [1:0] {
        CLR_IDLE  = 2'd0,
        CLR_HAVE1 = 2'd1,
        CLR_HAVE2 = 2'd2
    } clr_st_e;

    // Run/halt tracking, with halt split by whether counting survives
    typedef enum logic [1:0] {
        MD_RUN       = 2'd0,
        MD_HALT_LIVE = 2'd1,
        MD_HALT_HELD = 2'd2
    } mode_st_e;

endpackage

// File: rtl/wdc_clear_fsm.sv
module wdc_clear_fsm
    import wdc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    dual_mode,
    input  logic    clr_one,
    input  logic    clr_first,
    input  logic    clr_second,
    output logic    clr_fire,
    output clr_st_e st_o
);

    clr_st_e st_q, st_d;
    logic    seen_first, seen_second;

    // Merge the stored half of the pair with this cycle's strobes
    assign seen_first  = (st_q == CLR_HAVE1) || clr_first;
    assign seen_second = (st_q == CLR_HAVE2) || clr_second;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CLR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (!dual_mode) begin
            st_d = CLR_IDLE;
        end else begin
            unique case (st_q)
                CLR_IDLE: begin
                    if (clr_first && clr_second) st_d = CLR_IDLE;
                    else if (clr_first)          st_d = CLR_HAVE1;
                    else if (clr_second)         st_d = CLR_HAVE2;
                    else                         st_d = CLR_IDLE;
                end
                CLR_HAVE1: st_d = clr_second ? CLR_IDLE : CLR_HAVE1;
                CLR_HAVE2: st_d = clr_first  ? CLR_IDLE : CLR_HAVE2;
                default:   st_d = CLR_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        if (dual_mode) begin
            clr_fire = seen_first && seen_second;
        end else begin
            clr_fire = clr_one;
        end
        st_o = st_q;
    end

endmodule

// File: rtl/wdc_mode_fsm.sv
module wdc_mode_fsm
    import wdc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     halted,
    input  logic     src_sel,
    output logic     count_en,
    output logic     in_halt,
    output mode_st_e st_o
);

    mode_st_e st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MD_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: the source picked at halt entry stays for the whole halt
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MD_RUN: begin
                if (halted) st_d = src_sel ? MD_HALT_HELD : MD_HALT_LIVE;
                else        st_d = MD_RUN;
            end
            MD_HALT_LIVE: st_d = halted ? MD_HALT_LIVE : MD_RUN;
            MD_HALT_HELD: st_d = halted ? MD_HALT_HELD : MD_RUN;
            default:      st_d = MD_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        count_en = (st_q != MD_HALT_HELD);
        in_halt  = (st_q != MD_RUN);
        st_o     = st_q;
    end

endmodule

// File: rtl/wdc_counter.sv
module wdc_counter #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             count_en,
    input  logic             clr,
    input  logic             halt_flag,
    output logic             wrap_o,
    output logic             wrap_halt_o,
    output logic [PRE_W-1:0] pre_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step, pre_full, cnt_full, wrap_now;
    logic             wrap_q, wrap_halt_q;

    // A clear always beats a tick in the same cycle
    assign step     = tick && count_en && !clr;
    assign pre_full = &pre_q;
    assign cnt_full = &cnt_q;
    assign wrap_now = step && pre_full && cnt_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q       <= '0;
            cnt_q       <= '0;
            wrap_q      <= 1'b0;
            wrap_halt_q <= 1'b0;
        end else begin
            wrap_q      <= wrap_now;
            wrap_halt_q <= wrap_now && halt_flag;
            if (clr) begin
                pre_q <= '0;
                cnt_q <= '0;
            end else if (step) begin
                pre_q <= pre_q + 1'b1;
                if (pre_full) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign wrap_o      = wrap_q;
    assign wrap_halt_o = wrap_halt_q;
    assign pre_o       = pre_q;
    assign cnt_o       = cnt_q;

endmodule

// File: rtl/wdt_dualclr.sv
module wdt_dualclr
    import wdc_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic dual_mode,
    input  logic osc_tick,
    input  logic sys_tick,
    input  logic clr_one,
    input  logic clr_first,
    input  logic clr_second,
    input  logic halt_enter,
    input  logic halted,
    output logic tmo_pulse,
    output logic tmo_warm
);

    logic             tick_sel;
    logic             clr_fire, clr_any;
    logic             count_en, in_halt;
    clr_st_e          clr_st;
    mode_st_e         mode_st;
    logic [PRE_W-1:0] pre_w;
    logic [CNT_W-1:0] cnt_w;

    assign tick_sel = src_sel ? sys_tick : osc_tick;
    assign clr_any  = clr_fire || halt_enter;

    wdc_clear_fsm u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .dual_mode  (dual_mode),
        .clr_one    (clr_one),
        .clr_first  (clr_first),
        .clr_second (clr_second),
        .clr_fire   (clr_fire),
        .st_o       (clr_st)
    );

    wdc_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted   (halted),
        .src_sel  (src_sel),
        .count_en (count_en),
        .in_halt  (in_halt),
        .st_o     (mode_st)
    );

    wdc_counter #(
        .PRE_W (PRE_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_sel),
        .count_en    (count_en),
        .clr         (clr_any),
        .halt_flag   (in_halt),
        .wrap_o      (tmo_pulse),
        .wrap_halt_o (tmo_warm),
        .pre_o       (pre_w),
        .cnt_o       (cnt_w)
    );

endmodule

// File: rtl/wdc_chk.sv
module wdc_chk
    import wdc_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dual_mode,
    input logic             clr_one,
    input logic             halt_enter,
    input logic             clr_fire,
    input logic [1:0]       mode_st,
    input logic [PRE_W-1:0] pre_v,
    input logic [CNT_W-1:0] cnt_v,
    input logic             tmo_pulse,
    input logic             tmo_warm
);

    // R1
    tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> !tmo_pulse);

    // R7
    warm_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_warm |-> tmo_pulse);

    // R5
    halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter |=> (pre_v == '0 && cnt_v == '0 && !tmo_pulse));

    // R3
    single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && clr_one) |=> (pre_v == '0 && cnt_v == '0));

    // R6
    held_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'(MD_HALT_HELD) && !halt_enter && !clr_fire)
            |=> ($stable(pre_v) && $stable(cnt_v) && !tmo_pulse));

endmodule

bind wdt_dualclr wdc_chk #(
    .PRE_W (PRE_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dual_mode  (dual_mode),
    .clr_one    (clr_one),
    .halt_enter (halt_enter),
    .clr_fire   (clr_fire),
    .mode_st    (mode_st),
    .pre_v      (pre_w),
    .cnt_v      (cnt_w),
    .tmo_pulse  (tmo_pulse),
    .tmo_warm   (tmo_warm)
);

// File: tb/sim_wdt_dualclr.sv
`timescale 1ns/1ps
module sim_wdt_dualclr;

    localparam int PRE_W  = 2;
    localparam int CNT_W  = 3;
    localparam int PERIOD = 1 << (PRE_W + CNT_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_sel = 1'b0, dual_mode = 1'b0;
    logic osc_tick = 1'b0, sys_tick = 1'b0;
    logic clr_one = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
    logic halt_enter = 1'b0, halted = 1'b0;
    logic tmo_pulse, tmo_warm;

    int checks = 0;
    int errors = 0;

    // bench reference state
    int m_cnt = 0;
    int m_mode = 0;   // 0 running, 1 halted and counting, 2 halted and frozen
    bit m_p1 = 0, m_p2 = 0;

    always #4 clk = ~clk;

    wdt_dualclr #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dual_mode(dual_mode),
        .osc_tick(osc_tick), .sys_tick(sys_tick), .clr_one(clr_one),
        .clr_first(clr_first), .clr_second(clr_second),
        .halt_enter(halt_enter), .halted(halted),
        .tmo_pulse(tmo_pulse), .tmo_warm(tmo_warm)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // One cycle: t drives the selected source, the other source ticks every cycle
    task automatic go(input bit t, input bit c0, input bit c1, input bit c2,
                      input bit he, input string tag);
        bit en, tk, fire, clr, st, etmo, ewarm;
        osc_tick   = src_sel ? 1'b1 : t;
        sys_tick   = src_sel ? t : 1'b1;
        clr_one    = c0;
        clr_first  = c1;
        clr_second = c2;
        halt_enter = he;
        en    = (m_mode != 2);
        tk    = t;
        fire  = dual_mode ? ((m_p1 | c1) & (m_p2 | c2)) : c0;
        clr   = he | fire;
        st    = tk & en & !clr;
        etmo  = st && (m_cnt == PERIOD - 1);
        ewarm = etmo && (m_mode != 0);
        @(posedge clk);
        #2;
        check({tag, " pulse"}, tmo_pulse, etmo);
        check({tag, " warm"}, tmo_warm, ewarm);
        if (clr) m_cnt = 0;
        else if (st) m_cnt = (m_cnt + 1) % PERIOD;
        if (!dual_mode) begin
            m_p1 = 0; m_p2 = 0;
        end else if ((m_p1 | c1) & (m_p2 | c2)) begin
            m_p1 = 0; m_p2 = 0;
        end else begin
            m_p1 = m_p1 | c1; m_p2 = m_p2 | c2;
        end
        if (!halted) m_mode = 0;
        else if (m_mode == 0) m_mode = src_sel ? 2 : 1;
        clr_one = 0; clr_first = 0; clr_second = 0; halt_enter = 0;
    endtask

    task automatic sync_clear();
        go(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5_sync");
    endtask

    initial begin
        #10000000;
        errors++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R8_reset pulse", tmo_pulse, 1'b0);
        check("R8_reset warm", tmo_warm, 1'b0);
        rst_n = 1'b1;
        // R8 and R1: counting starts at once, period is exact, then wraps
        for (int i = 0; i < 2 * PERIOD + 3; i++) go(1'b1, 0, 0, 0, 0, "R8_R1_first");

        for (int s = 0; s < 2; s++) begin
            src_sel = s[0];
            // R2 and R1: sparse ticks on the selected source, other source busy
            dual_mode = 1'b0;
            sync_clear();
            for (int i = 0; i < 3 * PERIOD; i++) go(i % 3 != 1, 0, 0, 0, 0, "R2_sel");

            // R3, R9: single-mode clear at every offset, with a tick alongside
            for (int k = 0; k <= PERIOD + 1; k++) begin
                sync_clear();
                for (int i = 0; i < k; i++) go(1'b1, 0, 0, 0, 0, "R3_pre");
                go(1'b1, 1'b1, 0, 0, 0, "R9_single");
                for (int i = 0; i < PERIOD + 1; i++) go(1'b1, 0, i == 5, i == 9, 0, "R3_ignore");
            end

            // R4: dual mode, both orders and gaps, clr_one and repeats ignored
            dual_mode = 1'b1;
            for (int g = 0; g < 5; g++) begin
                for (int ord = 0; ord < 2; ord++) begin
                    sync_clear();
                    for (int i = 0; i < PERIOD - 4; i++) go(1'b1, i == 3, 0, 0, 0, "R4_one_ignored");
                    go(1'b1, 0, ord == 0, ord == 1, 0, "R4_half");
                    for (int i = 0; i < g; i++) go(1'b1, 0, ord == 0, ord == 1, 0, "R4_repeat");
                    go(1'b1, 0, ord == 1 || g == 0, ord == 0 || g == 0, 0, "R4_pair");
                    for (int i = 0; i < PERIOD + 2; i++) go(1'b1, 0, 0, 0, 0, "R4_after");
                end
            end

            // R5, R6, R7: halt entry, counting in halt by source, warm flag
            for (int k = 3; k < PERIOD; k += 7) begin
                sync_clear();
                for (int i = 0; i < k; i++) go(1'b1, 0, 0, 0, 0, "R5_pre");
                halted = 1'b1;
                go(1'b1, 0, 0, 0, 1'b1, "R5_halt");
                for (int i = 0; i < PERIOD + 4; i++) go(1'b1, 0, 0, 0, 0, "R6_R7_halt");
                halted = 1'b0;
                for (int i = 0; i < PERIOD + 2; i++) go(1'b1, 0, 0, 0, 0, "R6_R7_resume");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule